// File: doc/BRIEF.md
# Lookahead Priority Encoder with Folded Macro Wiring

This block takes a vector of request bits and marks the single request that wins under a fixed ordering: the lowest index has the highest priority. The result is a one-hot grant vector of the same width as the requests, together with a flag that tells whether any request was present at all. It is meant for arbitration paths, such as picking a router port, picking the first matching entry of an associative lookup, or similar first-one searches.

Internally the request vector is cut into 8-bit macros, and each macro into two 4-bit nibbles. A priority token ripples only inside a nibble. Each nibble and macro is disabled by a lookahead signal, which is the OR of every request of lower index. The macro-level lookahead signals are either rippled macro by macro or, in the folded arrangement, built from pairs of macros. In the folded arrangement a lower macro's request summary reaches non-adjacent macros directly, which shortens the longest path.

The request vector is captured into a register on a rising clock edge. The combinational core settles during the following cycle, and the grant and flag are registered on the next rising edge. Glitches inside the core therefore never appear at the outputs. Reset is synchronous and active high.

Top module: `lookahead_prio_encoder`

## Requirements
- R1: `grant_o` bit k is 1 exactly when request bit k was 1 and every request bit with an index below k was 0. Bit 0 has the highest priority.
- R2: `grant_o` never has more than one bit set.
- R3: `any_o` equals the OR of all request bits. It is 1 exactly when `grant_o` is nonzero.
- R4: An all-zero request vector gives an all-zero `grant_o` and `any_o` = 0.
- R5: A set request in any lower 8-bit group forces every grant bit of the higher groups to 0, whatever those groups request. Within a group, a set bit in the lower nibble forces the upper nibble's grants to 0.
- R6: When request bit 0 is 1, `grant_o` equals exactly 1 (only bit 0 set), whatever the other request bits are.
- R7: The chained setting (`FOLDED` = 0) and the folded setting (`FOLDED` = 1) of the inter-macro wiring give identical outputs for every request vector.
- R8: A request vector present at rising edge t appears at `grant_o` and `any_o` just after rising edge t+1. Before that edge the outputs keep their previous value.
- R9: While `rst` is high at a rising edge, `grant_o` and `any_o` become 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | REQ_W | Request bits; index 0 has the highest priority |
| grant_o | output | REQ_W | Registered one-hot grant of the lowest set request, or zero |
| any_o | output | 1 | Registered flag: at least one request was set |

## Verification
Every single-bit request vector is applied, along with the all-zero vector. Together these confirm that each bit position maps to its own grant, and that the empty case gives no grant. Each 8-bit group is then swept through all 256 patterns, once with the lower groups clear and random bits above, and once with a set bit just below the group. The first sweep exercises the nibble ripple and the group lookahead. The second shows that the lookahead fully disables a group. Random vectors, vectors with bit 0 set, and a cycle-by-cycle latency and reset sequence complete the checks. A chained and a folded instance are compared against the same arithmetic expectation, so any wiring difference between the two settings is reported.

// File: rtl/lpe_pkg.sv
package lpe_pkg;
  localparam int MACRO_W = 8;
  localparam int NIBBLE_W = 4;
endpackage

// File: rtl/lpe_nibble.sv
module lpe_nibble
  import lpe_pkg::*;
(
  input  logic [NIBBLE_W-1:0] d,
  input  logic                kill,
  output logic [NIBBLE_W-1:0] grant
);
  // token ripple: a bit may win only if no lower bit (or the kill) is set
  always_comb begin
    logic blocked;
    blocked = kill;
    for (int k = 0; k < NIBBLE_W; k++) begin
      grant[k] = d[k] & ~blocked;
      blocked  = blocked | d[k];
    end
  end
endmodule

// File: rtl/lpe_macro8.sv
module lpe_macro8
  import lpe_pkg::*;
(
  input  logic [MACRO_W-1:0] d,
  input  logic               la3_in,
  output logic [MACRO_W-1:0] grant,
  output logic               local_any
);
  logic la2;

  assign local_any = |d;
  assign la2       = (|d[NIBBLE_W-1:0]) | la3_in;

  lpe_nibble u_lo (
    .d    (d[NIBBLE_W-1:0]),
    .kill (la3_in),
    .grant(grant[NIBBLE_W-1:0])
  );

  lpe_nibble u_hi (
    .d    (d[MACRO_W-1:NIBBLE_W]),
    .kill (la2),
    .grant(grant[MACRO_W-1:NIBBLE_W])
  );

  // R5: an active incoming lookahead silences the whole macro
  always_comb begin
    if (la3_in === 1'b1) begin
      assert_macro_kill_R5: assert (grant == '0);
    end
  end
endmodule

// File: rtl/lpe_la_net.sv
module lpe_la_net #(
  parameter int NM     = 4,
  parameter bit FOLDED = 1'b1
) (
  input  logic [NM-1:0] macro_any,
  output logic [NM-1:0] la_in
);
  logic [NM-1:0] chain_la;

  always_comb begin
    chain_la[0] = 1'b0;
    for (int i = 1; i < NM; i++) begin
      chain_la[i] = chain_la[i-1] | macro_any[i-1];
    end
  end

  generate
    if (FOLDED) begin : g_fold
      localparam int NP = (NM + 1) / 2;
      logic [2*NP-1:0] any_pad;
      logic [2*NP-1:0] la_pad;
      logic [NP-1:0]   pair_any;
      logic [NP-1:0]   pair_pre;

      assign any_pad = (2*NP)'(macro_any);

      always_comb begin
        for (int g = 0; g < NP; g++) begin
          pair_any[g] = any_pad[2*g] | any_pad[2*g+1];
        end
        pair_pre[0] = 1'b0;
        for (int g = 1; g < NP; g++) begin
          pair_pre[g] = pair_pre[g-1] | pair_any[g-1];
        end
        // even macro takes the pair prefix; odd macro adds its partner directly
        for (int g = 0; g < NP; g++) begin
          la_pad[2*g]   = pair_pre[g];
          la_pad[2*g+1] = pair_pre[g] | any_pad[2*g];
        end
      end

      assign la_in = la_pad[NM-1:0];

      // R7: folded lookahead must equal the rippled lookahead
      always_comb begin
        if (!$isunknown(macro_any)) begin
          assert_fold_match_R7: assert (la_in == chain_la);
        end
      end
    end else begin : g_chain
      assign la_in = chain_la;
    end
  endgenerate
endmodule

// File: rtl/lookahead_prio_encoder.sv
module lookahead_prio_encoder
  import lpe_pkg::*;
#(
  parameter int REQ_W  = 32,
  parameter bit FOLDED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REQ_W-1:0] req_i,
  output logic [REQ_W-1:0] grant_o,
  output logic             any_o
);
  localparam int NM = REQ_W / MACRO_W;

  logic [REQ_W-1:0] req_q;
  logic [REQ_W-1:0] grant_c;
  logic [NM-1:0]    m_any;
  logic [NM-1:0]    la_in;
  logic             any_c;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_i;
  end

  lpe_la_net #(.NM(NM), .FOLDED(FOLDED)) u_net (
    .macro_any(m_any),
    .la_in    (la_in)
  );

  generate
    for (genvar m = 0; m < NM; m++) begin : g_macro
      lpe_macro8 u_m (
        .d        (req_q[m*MACRO_W +: MACRO_W]),
        .la3_in   (la_in[m]),
        .grant    (grant_c[m*MACRO_W +: MACRO_W]),
        .local_any(m_any[m])
      );
    end
  endgenerate

  assign any_c = la_in[NM-1] | m_any[NM-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      any_o   <= 1'b0;
    end else begin
      grant_o <= grant_c;
      any_o   <= any_c;
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  assert_any_match_R3: assert property (@(posedge clk) disable iff (rst)
    any_o == (grant_o != '0));

  assert_bit0_wins_R6: assert property (@(posedge clk) disable iff (rst)
    req_q[0] |=> (grant_o == REQ_W'(1)));

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (req_q == '0) |=> !any_o);
endmodule

// File: tb/lookahead_prio_encoder_tb_top.sv
module lookahead_prio_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] req = '0;
  logic [W-1:0] g_f, g_c;
  logic a_f, a_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lookahead_prio_encoder #(.REQ_W(W), .FOLDED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .grant_o(g_f), .any_o(a_f));

  lookahead_prio_encoder #(.REQ_W(W), .FOLDED(1'b0)) dut_chain_i (
    .clk(clk), .rst(rst), .req_i(req), .grant_o(g_c), .any_o(a_c));

  function automatic logic [W-1:0] lowest(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) begin
      if (v[i]) return W'(1) << i;
    end
    return '0;
  endfunction

  task automatic expect_out(input logic [W-1:0] eg, input logic ea, input string tag);
    checks++;
    if (g_f !== eg || a_f !== ea) begin
      failures++;
      $display("FAIL %s folded: grant=%h any=%b expected grant=%h any=%b", tag, g_f, a_f, eg, ea);
    end
    checks++;
    if (g_c !== eg || a_c !== ea) begin
      failures++;
      $display("FAIL %s/R7 chained: grant=%h any=%b expected grant=%h any=%b", tag, g_c, a_c, eg, ea);
    end
  endtask

  task automatic apply(input logic [W-1:0] v, input string tag);
    @(negedge clk);
    req = v;
    @(posedge clk);
    @(posedge clk);
    #1;
    expect_out(lowest(v), |v, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs at zero even with requests present
    req = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    expect_out('0, 1'b0, "R9");
    @(negedge clk);
    rst = 1'b0;

    // R4: empty request vector
    apply('0, "R4");

    // R1: every single-bit vector
    for (int i = 0; i < W; i++) apply(W'(1) << i, "R1");

    // R8: latency, output changes only after the second edge
    apply('0, "R8");
    @(negedge clk);
    req = W'(1) << 13;
    @(posedge clk);
    #1;
    expect_out('0, 1'b0, "R8");
    @(posedge clk);
    #1;
    expect_out(W'(1) << 13, 1'b1, "R8");

    // R1/R5: sweep each 8-bit group with lower groups clear, random bits above
    for (int m = 0; m < W/8; m++) begin
      for (int p = 0; p < 256; p++) begin
        logic [W-1:0] above;
        above = $urandom() & (32'hFFFF_FFFF << (8*m + 8));
        apply((W'(p) << (8*m)) | above, "R1");
      end
    end

    // R5: a set bit just below a group silences that group and everything above
    for (int m = 1; m < W/8; m++) begin
      for (int p = 0; p < 256; p++) begin
        logic [W-1:0] v;
        v = (W'(p) << (8*m)) | (W'(1) << (8*m - 1)) | ($urandom() & (32'hFFFF_FFFF << (8*m + 8)));
        apply(v, "R5");
      end
    end

    // R5: nibble lookahead inside each group, lower nibble bit with full upper nibble
    for (int m = 0; m < W/8; m++) begin
      for (int b = 0; b < 4; b++) begin
        apply((W'(8'hF0 | (1 << b)) << (8*m)), "R5");
      end
    end

    // R6: bit 0 set wins regardless of the others
    for (int k = 0; k < 64; k++) apply($urandom() | 32'h1, "R6");

    // R2/R3/R7: random vectors
    for (int k = 0; k < 800; k++) apply($urandom(), "R2");
    for (int k = 0; k < 200; k++) apply($urandom() & $urandom() & $urandom(), "R3");

    // R9: reset during operation clears registered outputs
    apply(32'h0004_0000, "R1");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    expect_out('0, 1'b0, "R9");
    @(negedge clk);
    rst = 1'b0;
    apply(32'h8000_0000, "R1");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule